// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Controller

This block is a register-mapped bank of general-purpose pins, `NPINS` wide (32 by default). A small synchronous register bus drives it. Software reads the synchronised pin levels and sets the direction of each pin. It changes the output data through separate set and clear words, so no read-modify-write is ever needed.

Every pin also feeds an interrupt detector. Per-pin configuration bits choose edge or level detection, choose the active polarity, and allow detection on both edges. A detected event latches a pending bit. The pending bits are acknowledged by writing ones to them, and enable bits are changed only through set and clear words. The single interrupt output is high while any pending bit is also enabled.

Bus accesses complete in one cycle. A write is a cycle with `bus_en` and `bus_we` high. Read data is combinational from the addressed register while `bus_en` is high with `bus_we` low, and reads have no side effects.

Word addresses: 0 input level (read only, writes ignored); 1 output set; 2 output clear (both read back the output register); 3 direction; 4 enable set; 5 enable clear (both read back the enable register); 6 pending (read, write one to acknowledge); 7 detect mode; 8 polarity; 9 both-edge. Unused addresses read zero.

Top module: `gpio_irq_bank`

## Requirements
- R1: A write to address 1 sets each output bit where the write data is 1. A write to address 2 clears each output bit where the write data is 1. Zero bits leave the output unchanged. `pin_o` shows the output register.
- R2: Address 3 is a read/write direction register with reset value 0. `pin_oe` bit n is 1 (pin driven) exactly when direction bit n is 1.
- R3: A read of address 0 returns the pin inputs through a two-flop synchroniser. After a change on `pin_i`, the new value is readable after the second rising edge and not after the first.
- R4: A write to address 4 sets the enable bits where the data is 1, and a write to address 5 clears them. Zero bits have no effect. Both addresses read back the enable register.
- R5: With mode bit 1 (edge), polarity bit 1 and both-edge bit 0, a rising pin sets its pending bit at the third rising clock edge after the pin change. The bit stays set after the pin falls until it is acknowledged.
- R6: With mode bit 1 and polarity bit 0, a falling pin sets the pending bit and a rising pin does not.
- R7: With mode bit 1 and both-edge bit 1, either transition sets the pending bit, whatever the polarity.
- R8: With mode bit 0 (level), the pending bit is set while the synchronised level equals the polarity bit. An acknowledge while the level is still active leaves the bit set.
- R9: Writing 1 to a pending bit at address 6 clears it. If a new event for that pin is detected in the same cycle as the acknowledge, the bit stays set. Pending bits never set without a detected event.
- R10: After reset, output, direction, enable, pending, mode and both-edge registers are 0, and polarity is all ones (active high). `irq_o` is 0.
- R11: `irq_o` is 1 exactly when some bit is both pending and enabled. Pending bits latch even while the pin's enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Asynchronous pin inputs |
| pin_o | output | NPINS | Output data register |
| pin_oe | output | NPINS | Output enable (direction) |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data of the addressed register |
| irq_o | output | 1 | Combined interrupt |

## Verification
Several properties are checked on every cycle:
- set and clear writes to the output and enable registers take effect at the next edge;
- an unacknowledged pending bit is never lost;
- no pending bit rises without a detected event in the previous cycle.

Other behaviours only the bench's scenarios can show:
- the exact three-edge latency from pin to pending;
- the polarity and both-edge choices;
- the level-mode re-assertion after an acknowledge;
- an event colliding with an acknowledge.

A reference model in the bench tracks random pin activity and configuration writes, and the bench compares the pending register and `irq_o` against it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        A_IN    = 4'd0,
        A_OSET  = 4'd1,
        A_OCLR  = 4'd2,
        A_DIR   = 4'd3,
        A_ESET  = 4'd4,
        A_ECLR  = 4'd5,
        A_PEND  = 4'd6,
        A_MODE  = 4'd7,
        A_POL   = 4'd8,
        A_BOTH  = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] lvl_o,
    output logic [NPINS-1:0] prev_o
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1   = pin_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl_o  = sync_q.s2;
    assign prev_o = sync_q.prev;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] prev,
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] both,
    output logic [NPINS-1:0] hit
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall, lvl_act, edge_act;
        always_comb begin
            rise     = lvl[i] & ~prev[i];
            fall     = ~lvl[i] & prev[i];
            lvl_act  = (lvl[i] == pol[i]);
            if (both[i]) edge_act = rise | fall;
            else         edge_act = pol[i] ? rise : fall;
            hit[i]   = mode[i] ? edge_act : lvl_act;
        end
    end
endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] ack,
    output logic [NPINS-1:0] pend_q
);
    logic [NPINS-1:0] pend_d;

    always_comb begin
        // a fresh event outranks an acknowledge of the same bit
        pend_d = (pend_q & ~ack) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq_o
);
    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] both;
    } regs_t;

    localparam logic [NPINS-1:0] POL_RST = '1;

    regs_t regs_d, regs_q;
    logic [NPINS-1:0] lvl, prev, hit, ack, pend_q, en_vec;
    logic wr;

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .lvl_o(lvl), .prev_o(prev)
    );

    gpio_trig_detect #(.NPINS(NPINS)) u_det (
        .lvl(lvl), .prev(prev), .mode(regs_q.mode), .pol(regs_q.pol),
        .both(regs_q.both), .hit(hit)
    );

    gpio_irq_pend #(.NPINS(NPINS)) u_pend (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ack(ack), .pend_q(pend_q)
    );

    assign wr  = bus_en & bus_we;
    assign ack = (wr && bus_addr == A_PEND) ? bus_wdata : '0;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (bus_addr)
                A_OSET: regs_d.dout = regs_q.dout | bus_wdata;
                A_OCLR: regs_d.dout = regs_q.dout & ~bus_wdata;
                A_DIR:  regs_d.dir  = bus_wdata;
                A_ESET: regs_d.en   = regs_q.en | bus_wdata;
                A_ECLR: regs_d.en   = regs_q.en & ~bus_wdata;
                A_MODE: regs_d.mode = bus_wdata;
                A_POL:  regs_d.pol  = bus_wdata;
                A_BOTH: regs_d.both = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.pol <= POL_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (bus_addr)
                A_IN:           bus_rdata = lvl;
                A_OSET, A_OCLR: bus_rdata = regs_q.dout;
                A_DIR:          bus_rdata = regs_q.dir;
                A_ESET, A_ECLR: bus_rdata = regs_q.en;
                A_PEND:         bus_rdata = pend_q;
                A_MODE:         bus_rdata = regs_q.mode;
                A_POL:          bus_rdata = regs_q.pol;
                A_BOTH:         bus_rdata = regs_q.both;
                default:        bus_rdata = '0;
            endcase
        end
    end

    assign en_vec = regs_q.en;
    assign pin_o  = regs_q.dout;
    assign pin_oe = regs_q.dir;
    assign irq_o  = |(pend_q & en_vec);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_o,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  pend_q,
    input logic [NPINS-1:0]  hit,
    input logic [NPINS-1:0]  ack
);
    logic wr;
    assign wr = bus_en & bus_we;

    a_r1_out_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_OSET) |=> ((pin_o & $past(bus_wdata)) == $past(bus_wdata)));

    a_r1_out_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_OCLR) |=> ((pin_o & $past(bus_wdata)) == '0));

    a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_ESET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r4_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_ECLR) |=> ((en_q & $past(bus_wdata)) == '0));

    a_r5_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend_q & $past(pend_q & ~ack)) == '0));

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_o(pin_o),
    .en_q(en_vec), .pend_q(pend_q), .hit(hit), .ack(ack)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    localparam int N = 32;
    localparam logic [3:0] AIN = 0, AOSET = 1, AOCLR = 2, ADIR = 3, AESET = 4,
                           AECLR = 5, APEND = 6, AMODE = 7, APOL = 8, ABOTH = 9;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] pin_i = '0, pin_o, pin_oe, bus_wdata = '0, bus_rdata;
    logic bus_en = 0, bus_we = 0, irq_o;
    logic [3:0] bus_addr = '0;
    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_irq_bank #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // reference model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_prev, m_pend, m_en, m_mode, m_pol, m_both;

    function automatic logic [N-1:0] exp_hit(logic [N-1:0] s, logic [N-1:0] p,
            logic [N-1:0] md, logic [N-1:0] pl, logic [N-1:0] bt);
        logic [N-1:0] h;
        for (int i = 0; i < N; i++) begin
            if (!md[i])     h[i] = (s[i] == pl[i]);
            else if (bt[i]) h[i] = s[i] != p[i];
            else if (pl[i]) h[i] = s[i] & ~p[i];
            else            h[i] = ~s[i] & p[i];
        end
        return h;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0; m_en <= '0;
            m_mode <= '0; m_pol <= '1; m_both <= '0;
        end else begin
            logic [N-1:0] a;
            a = (bus_en && bus_we && bus_addr == APEND) ? bus_wdata : '0;
            m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
            m_pend <= (m_pend & ~a) | exp_hit(m_s2, m_prev, m_mode, m_pol, m_both);
            if (bus_en && bus_we) begin
                case (bus_addr)
                    AESET: m_en <= m_en | bus_wdata;
                    AECLR: m_en <= m_en & ~bus_wdata;
                    AMODE: m_mode <= bus_wdata;
                    APOL:  m_pol <= bus_wdata;
                    ABOTH: m_both <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [N-1:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [N-1:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset values
        rd(AOSET, d); chk("R10 out", d, '0);
        rd(ADIR, d);  chk("R10 dir", d, '0);
        rd(AESET, d); chk("R10 en", d, '0);
        rd(APEND, d); chk("R10 pend", d, '0);
        rd(AMODE, d); chk("R10 mode", d, '0);
        rd(APOL, d);  chk("R10 pol", d, '1);
        rd(ABOTH, d); chk("R10 both", d, '0);
        chk("R10 irq", {31'b0, irq_o}, '0);

        // R1 output set / clear
        wr(AOSET, 32'hF0F0_0000); chk("R1 set", pin_o, 32'hF0F0_0000);
        wr(AOSET, 32'h0000_000F); chk("R1 set2", pin_o, 32'hF0F0_000F);
        wr(AOCLR, 32'h00F0_0001); chk("R1 clr", pin_o, 32'hF000_000E);
        wr(AOCLR, 32'h0);         chk("R1 zero", pin_o, 32'hF000_000E);
        rd(AOCLR, d);             chk("R1 readback", d, 32'hF000_000E);
        // R2 direction
        wr(ADIR, 32'h1234_5678);  chk("R2 oe", pin_oe, 32'h1234_5678);
        rd(ADIR, d);              chk("R2 readback", d, 32'h1234_5678);
        // R3 input synchroniser latency; writes to address 0 ignored
        wr(AIN, 32'hFFFF_FFFF);
        rd(AIN, d);               chk("R3 write ignored", d, '0);
        pin_i = 32'h8000_0000;
        @(negedge clk); rd(AIN, d); chk("R3 one edge", d, '0);
        @(negedge clk); rd(AIN, d); chk("R3 two edges", d, 32'h8000_0000);
        // R8 would fire on pin31 in level-high mode; clear it again
        pin_i = '0; idle(3); wr(APEND, 32'h8000_0000);
        rd(APEND, d); chk("R8 level cleared", d, '0);
        // R4 enable set / clear
        wr(AESET, 32'h0000_00FF); rd(AESET, d); chk("R4 set", d, 32'h0000_00FF);
        wr(AECLR, 32'h0000_00F0); rd(AECLR, d); chk("R4 clr", d, 32'h0000_000F);
        wr(AESET, 32'h0);         rd(AESET, d); chk("R4 zero", d, 32'h0000_000F);

        // R5 rising edge on pin0
        wr(AMODE, 32'h0000_0007);
        wr(ABOTH, 32'h0000_0004);
        wr(APOL,  32'hFFFF_FFFD);
        pin_i[0] = 1;
        idle(2); rd(APEND, d); chk("R5 latency two", {31'b0, d[0]}, '0);
        idle(1); rd(APEND, d); chk("R5 latency three", {31'b0, d[0]}, 1);
        chk("R11 irq on", {31'b0, irq_o}, 1);
        pin_i[0] = 0; idle(4);
        rd(APEND, d); chk("R5 hold", {31'b0, d[0]}, 1);
        wr(APEND, 32'h1);
        rd(APEND, d); chk("R9 ack", {31'b0, d[0]}, '0);
        chk("R11 irq off", {31'b0, irq_o}, '0);

        // R6 falling edge on pin1
        pin_i[1] = 1; idle(4);
        rd(APEND, d); chk("R6 rise ignored", {31'b0, d[1]}, '0);
        pin_i[1] = 0; idle(4);
        rd(APEND, d); chk("R6 fall", {31'b0, d[1]}, 1);
        wr(APEND, 32'h2);

        // R7 both edges on pin2
        pin_i[2] = 1; idle(4);
        rd(APEND, d); chk("R7 rise", {31'b0, d[2]}, 1);
        wr(APEND, 32'h4);
        rd(APEND, d); chk("R7 acked", {31'b0, d[2]}, '0);
        pin_i[2] = 0; idle(4);
        rd(APEND, d); chk("R7 fall", {31'b0, d[2]}, 1);
        wr(APEND, 32'h4);

        // R8 level high on pin3
        pin_i[3] = 1; idle(4);
        rd(APEND, d); chk("R8 level set", {31'b0, d[3]}, 1);
        wr(APEND, 32'h8); idle(1);
        rd(APEND, d); chk("R8 reassert", {31'b0, d[3]}, 1);
        pin_i[3] = 0; idle(3); wr(APEND, 32'h8);
        rd(APEND, d); chk("R8 released", {31'b0, d[3]}, '0);

        // R11 pending latches while disabled (pin8 level high, enable off)
        pin_i[8] = 1; idle(4);
        rd(APEND, d); chk("R11 latch disabled", {31'b0, d[8]}, 1);
        chk("R11 irq masked", {31'b0, irq_o}, '0);
        wr(AESET, 32'h100);
        chk("R11 irq enabled", {31'b0, irq_o}, 1);
        pin_i[8] = 0; idle(3); wr(APEND, 32'h100);

        // R9 collision: pin0 pending, new rising edge meets the acknowledge
        pin_i[0] = 1; idle(4); pin_i[0] = 0; idle(4);
        rd(APEND, d); chk("R9 pre", {31'b0, d[0]}, 1);
        pin_i[0] = 1;
        @(negedge clk); @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = APEND; bus_wdata = 32'h1;
        @(negedge clk); bus_en = 0; bus_we = 0;
        rd(APEND, d); chk("R9 event wins", {31'b0, d[0]}, 1);
        wr(APEND, 32'h1);
        rd(APEND, d); chk("R9 later ack", {31'b0, d[0]}, '0);

        // random phase against the model (R5-R9, R11)
        for (int it = 0; it < 3000; it++) begin
            int op;
            @(negedge clk);
            bus_en = 0; bus_we = 0;
            chk("R11 irq model", {31'b0, irq_o}, {31'b0, |(m_pend & m_en)});
            pin_i = pin_i ^ ($urandom & $urandom & $urandom);
            op = $urandom_range(0, 8);
            if (op <= 2) begin
                rd(APEND, d); chk("R9 pend model", d, m_pend);
            end else begin
                bus_en = 1; bus_we = 1;
                bus_wdata = $urandom;
                case (op)
                    3: bus_addr = AMODE;
                    4: bus_addr = APOL;
                    5: bus_addr = ABOTH;
                    6: bus_addr = AESET;
                    7: bus_addr = AECLR;
                    default: bus_addr = APEND;
                endcase
            end
        end
        @(negedge clk); bus_en = 0; bus_we = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule